// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a timer. It watches an external input, cleans it up, picks out the edges it has been told to care about, and then takes only every first, second, fourth or eighth of those edges. On each such edge it records the value of the timer's running counter and sets a sticky channel flag. A timer holds four copies of this block, and the copies share nothing but the clock, the reset and the counter bus.

The input path has four stages that always come in the same order. First the input goes through a two-flop synchroniser. A programmable digital filter follows, and it accepts a new level only once that level has held for N clocks in a row. Next comes a rising/falling selector that feeds the edge detector. Last is an event prescaler. The captured counter value and the flag both update on the clock edge where the prescaler fires. The flag stays set until a clear strobe removes it. An interrupt output is driven while the flag is set and the interrupt enable is high.

Top module: `cap_chan`

## Requirements
- R1: While reset is held and right after it is released, `cap_val_o` is 0, `flag_o` is 0 and `irq_o` is 0.
- R2: A level change on `pin_i` that is first sampled at clock edge k is captured at clock edge k+2+M, where M is `flt_len_i`, or 1 when `flt_len_i` is 0. The input passes through two synchroniser flops before it reaches the filter.
- R3: When `flt_len_i` is N with N of 1 or more, the filtered level changes only after the synchronised input has differed from it on N consecutive clocks. A shorter pulse produces no capture. A value of 0 bypasses the filter.
- R4: When `edge_sel_i` is 0, only rising edges of the filtered level qualify. When it is 1, only falling edges qualify.
- R5: `psc_sel_i` values 0, 1, 2 and 3 make a capture happen on every 1st, 2nd, 4th or 8th qualified edge.
- R6: Any change of `psc_sel_i` restarts the qualified-edge count. A qualified edge in the same cycle as the change counts as the first edge under the new ratio.
- R7: On a capture edge, `cap_val_o` takes the value `cnt_i` has at that edge and `flag_o` becomes 1 on the same edge. Between captures `cap_val_o` does not change.
- R8: `flag_o` stays at 1 until a cycle with `flag_clr_i` high and no capture clears it. A capture in the same cycle as a clear leaves the flag at 1.
- R9: `irq_o` is high exactly when `flag_o` is 1 and `irq_en_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Raw asynchronous channel input |
| flt_len_i | input | FLT_W (4) | Filter run length N, where 0 means bypass |
| edge_sel_i | input | 1 | 0 selects rising edges, 1 selects falling edges |
| psc_sel_i | input | PSC_W (2) | Edge prescaler ratio select (divide by 2^value) |
| cnt_i | input | CNT_W (16) | Running timer counter value |
| cap_val_o | output | CNT_W (16) | Last captured counter value |
| flag_o | output | 1 | Sticky capture flag |
| flag_clr_i | input | 1 | Strobe that clears the flag |
| irq_en_i | input | 1 | Interrupt enable |
| irq_o | output | 1 | Channel interrupt |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter, a 4-bit filter length, two synchroniser stages, the filter generated in, and a 2-bit prescaler select. These settings make every divide ratio up to 8 reachable. They also allow filter lengths from bypass through 15, including values changed in the middle of a run, where the run counter can go past the new limit and wrap. With the 2-bit select, switching ratio while a partial count is pending can be shown to restart the count. A 4-bit run counter keeps the glitch rejection at lengths 4 and 5 within short directed sequences.

// File: rtl/cap_chan_pkg.sv
package cap_chan_pkg;

   localparam int unsigned SYNC_MIN  = 2;
   localparam int unsigned PSC_W_MAX = 3;

   typedef enum logic {
      POL_RISE = 1'b0,
      POL_FALL = 1'b1
   } cap_pol_e;

   // Width of the qualified-edge counter needed for the largest ratio.
   function automatic int unsigned psc_cnt_width(input int unsigned psc_w);
      return (1 << psc_w) - 1;
   endfunction

endpackage

// File: rtl/cap_in_filter.sv
module cap_in_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FLT_W       = 4,
   parameter bit          FLT_EN      = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pin_i,
   input  logic [FLT_W-1:0] flt_len_i,
   output logic             lvl_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   smp;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end

   assign smp = sync_q[SYNC_STAGES-1];

   if (FLT_EN) begin : g_flt
      logic [FLT_W-1:0] run_q;
      logic             lvl_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            run_q <= '0;
            lvl_q <= 1'b0;
         end else if (flt_len_i == '0) begin
            run_q <= '0;
            lvl_q <= smp;
         end else if (smp == lvl_q) begin
            run_q <= '0;
         end else if (run_q == flt_len_i - FLT_W'(1)) begin
            run_q <= '0;
            lvl_q <= smp;
         end else begin
            run_q <= run_q + FLT_W'(1);
         end
      end

      assign lvl_o = lvl_q;
   end else begin : g_noflt
      logic lvl_q;
      logic unused_len;

      assign unused_len = ^flt_len_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) lvl_q <= 1'b0;
         else         lvl_q <= smp;
      end

      assign lvl_o = lvl_q;
   end

endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   input  logic edge_sel_i,
   output logic edge_o
);

   logic lvl_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= lvl_i;
   end

   assign rise   = lvl_i & ~lvl_q;
   assign fall   = ~lvl_i & lvl_q;
   assign edge_o = (edge_sel_i == cap_chan_pkg::POL_FALL) ? fall : rise;

endmodule

// File: rtl/cap_evt_psc.sv
module cap_evt_psc #(
   parameter int unsigned PSC_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             edge_i,
   input  logic [PSC_W-1:0] psc_sel_i,
   output logic             fire_o
);

   localparam int unsigned PC_W = cap_chan_pkg::psc_cnt_width(PSC_W);

   logic [PSC_W-1:0] sel_q;
   logic [PC_W-1:0]  cnt_q;
   logic [PC_W-1:0]  cnt_eff;
   logic [PC_W-1:0]  lim;
   logic             chg;

   assign chg     = (psc_sel_i != sel_q);
   assign cnt_eff = chg ? '0 : cnt_q;
   assign lim     = PC_W'((32'd1 << psc_sel_i) - 32'd1);
   assign fire_o  = edge_i && (cnt_eff == lim);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= '0;
         cnt_q <= '0;
      end else begin
         sel_q <= psc_sel_i;
         if (edge_i) cnt_q <= fire_o ? '0 : cnt_eff + PC_W'(1);
         else        cnt_q <= cnt_eff;
      end
   end

endmodule

// File: rtl/cap_chan.sv
module cap_chan #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned FLT_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          FLT_EN      = 1'b1,
   parameter int unsigned PSC_W       = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pin_i,
   input  logic [FLT_W-1:0] flt_len_i,
   input  logic             edge_sel_i,
   input  logic [PSC_W-1:0] psc_sel_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] cap_val_o,
   output logic             flag_o,
   input  logic             flag_clr_i,
   input  logic             irq_en_i,
   output logic             irq_o
);

   if (SYNC_STAGES < cap_chan_pkg::SYNC_MIN) begin : g_bad_sync
      $error("cap_chan: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1 || FLT_W < 1) begin : g_bad_width
      $error("cap_chan: CNT_W and FLT_W must be positive");
   end
   if (PSC_W < 1 || PSC_W > cap_chan_pkg::PSC_W_MAX) begin : g_bad_psc
      $error("cap_chan: PSC_W must be 1 to 3");
   end

   logic             lvl;
   logic             edge_pulse;
   logic             cap_fire;
   logic [CNT_W-1:0] cap_q;
   logic             flag_q;

   cap_in_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FLT_W       (FLT_W),
      .FLT_EN      (FLT_EN)
   ) u_flt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (pin_i),
      .flt_len_i (flt_len_i),
      .lvl_o     (lvl)
   );

   cap_edge_det u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_i      (lvl),
      .edge_sel_i (edge_sel_i),
      .edge_o     (edge_pulse)
   );

   cap_evt_psc #(
      .PSC_W (PSC_W)
   ) u_psc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .edge_i    (edge_pulse),
      .psc_sel_i (psc_sel_i),
      .fire_o    (cap_fire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cap_q  <= '0;
         flag_q <= 1'b0;
      end else if (cap_fire) begin
         cap_q  <= cnt_i;
         flag_q <= 1'b1;
      end else if (flag_clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign cap_val_o = cap_q;
   assign flag_o    = flag_q;
   assign irq_o     = flag_q & irq_en_i;

endmodule

// File: rtl/cap_chan_chk.sv
module cap_chan_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             cap_fire,
   input logic             edge_pulse,
   input logic             flag_o,
   input logic             flag_clr_i,
   input logic             irq_o,
   input logic             irq_en_i,
   input logic [CNT_W-1:0] cap_val_o,
   input logic [CNT_W-1:0] cnt_i
);

   AST_FIRE_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni) cap_fire |-> edge_pulse); // R5
   AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) edge_pulse |=> !edge_pulse); // R4
   AST_CAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) cap_fire |=> (cap_val_o == $past(cnt_i))); // R7
   AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !cap_fire |=> $stable(cap_val_o)); // R7
   AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) cap_fire |=> flag_o); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) (flag_o && !flag_clr_i) |=> flag_o); // R8
   AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) (flag_clr_i && !cap_fire) |=> !flag_o); // R8
   AST_IRQ_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) (cap_fire && irq_en_i) |=> (irq_o || !irq_en_i)); // R9

endmodule

bind cap_chan cap_chan_chk #(
   .CNT_W (CNT_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cap_fire   (cap_fire),
   .edge_pulse (edge_pulse),
   .flag_o     (flag_o),
   .flag_clr_i (flag_clr_i),
   .irq_o      (irq_o),
   .irq_en_i   (irq_en_i),
   .cap_val_o  (cap_val_o),
   .cnt_i      (cnt_i)
);

// File: tb/cap_chan_tb.sv
module cap_chan_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin = 1'b0;
   logic [3:0]  flt = 4'd0;
   logic        esel = 1'b0;
   logic [1:0]  psc = 2'd0;
   logic [15:0] cnt = 16'd0;
   logic [15:0] cap;
   logic        flag;
   logic        clr = 1'b0;
   logic        irq_en = 1'b0;
   logic        irq;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string cur_tag = "R7";

   // reference model state
   logic        m_s1, m_s2, m_lvl, m_lvlq, m_flag;
   logic [3:0]  m_run;
   logic [1:0]  m_pscq;
   logic [2:0]  m_pc;
   logic [15:0] m_cap;

   always #10 clk = ~clk;

   cap_chan u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .pin_i      (pin),
      .flt_len_i  (flt),
      .edge_sel_i (esel),
      .psc_sel_i  (psc),
      .cnt_i      (cnt),
      .cap_val_o  (cap),
      .flag_o     (flag),
      .flag_clr_i (clr),
      .irq_en_i   (irq_en),
      .irq_o      (irq)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_lvl = 0; m_lvlq = 0; m_flag = 0;
         m_run = 0; m_pscq = 0; m_pc = 0; m_cap = 0;
      end else begin
         logic       e, fire;
         logic [2:0] eff, lim;
         e    = esel ? (!m_lvl && m_lvlq) : (m_lvl && !m_lvlq);
         eff  = (psc != m_pscq) ? 3'd0 : m_pc;
         lim  = 3'((1 << psc) - 1);
         fire = e && (eff == lim);
         m_pc   = e ? (fire ? 3'd0 : eff + 3'd1) : eff;
         m_pscq = psc;
         if (fire) begin m_cap = cnt; m_flag = 1; end
         else if (clr) m_flag = 0;
         m_lvlq = m_lvl;
         if (flt == 0) begin m_lvl = m_s2; m_run = 0; end
         else if (m_s2 == m_lvl) m_run = 0;
         else if (m_run == flt - 4'd1) begin m_lvl = m_s2; m_run = 0; end
         else m_run = m_run + 4'd1;
         m_s2 = m_s1;
         m_s1 = pin;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (rst_n) begin
         chk(cur_tag, {16'd0, cap}, {16'd0, m_cap});
         chk(cur_tag, {31'd0, flag}, {31'd0, m_flag});
         chk("R9", {31'd0, irq}, {31'd0, m_flag & irq_en});
      end
   endtask

   task automatic clear_flag();
      clr = 1; tick(); clr = 0; tick();
   endtask

   task automatic pulse();
      pin = 1; repeat (3) tick();
      pin = 0; repeat (3) tick();
   endtask

   task automatic lat_test(input int n);
      int m;
      m = (n == 0) ? 1 : n;
      flt = 4'(n); pin = 0; psc = 0; esel = 0;
      repeat (n + 6) tick();
      clear_flag();
      for (int i = 0; i <= 3 + m; i++) begin
         tick();
         if (i == 2 + m) chk("R2", {31'd0, flag}, 0);
         if (i == 3 + m) begin
            chk("R2", {31'd0, flag}, 1);
            chk("R7", {16'd0, cap}, 32'(100 + 2 + m));
         end
         cnt = 16'(100 + i);
         if (i == 0) pin = 1;
      end
      pin = 0; repeat (n + 6) tick();
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int hold;
      void'($urandom(32'd4242));
      irq_en = 1;
      repeat (3) @(negedge clk);
      cur_tag = "R1";
      chk("R1", {16'd0, cap}, 0);
      chk("R1", {31'd0, flag}, 0);
      chk("R1", {31'd0, irq}, 0);
      rst_n = 1;
      tick();
      chk("R1", {16'd0, cap}, 0);
      chk("R1", {31'd0, flag}, 0);

      cur_tag = "R2";
      lat_test(0);
      lat_test(1);
      lat_test(3);

      cur_tag = "R3";
      flt = 4; pin = 0; repeat (10) tick();
      clear_flag();
      pin = 1; repeat (3) tick();
      pin = 0; repeat (15) tick();
      chk("R3", {31'd0, flag}, 0);
      pin = 1; repeat (4) tick();
      pin = 0; repeat (15) tick();
      chk("R3", {31'd0, flag}, 1);

      cur_tag = "R4";
      flt = 0; esel = 1; repeat (6) tick();
      clear_flag();
      pin = 1; repeat (6) tick();
      chk("R4", {31'd0, flag}, 0);
      pin = 0; repeat (6) tick();
      chk("R4", {31'd0, flag}, 1);
      esel = 0;

      cur_tag = "R5";
      psc = 2; tick();
      clear_flag();
      for (int e = 1; e <= 4; e++) begin
         pulse();
         if (e == 3) chk("R5", {31'd0, flag}, 0);
         if (e == 4) chk("R5", {31'd0, flag}, 1);
      end

      cur_tag = "R6";
      psc = 3; tick();
      clear_flag();
      repeat (3) pulse();
      psc = 1; tick();
      pulse();
      chk("R6", {31'd0, flag}, 0);
      pulse();
      chk("R6", {31'd0, flag}, 1);

      cur_tag = "R8";
      psc = 0; pulse();
      for (int i = 0; i <= 4; i++) begin
         tick();
         if (i == 4) begin
            chk("R8", {31'd0, flag}, 1);
            chk("R7", {16'd0, cap}, 32'd203);
         end
         cnt = 16'(200 + i);
         clr = (i == 3);
         if (i == 0) pin = 1;
      end
      clr = 0; pin = 0; repeat (4) tick();
      clear_flag();
      chk("R8", {31'd0, flag}, 0);

      cur_tag = "R9";
      pulse();
      irq_en = 0; #1;
      chk("R9", {31'd0, irq}, 0);
      irq_en = 1; #1;
      chk("R9", {31'd0, irq}, 1);

      cur_tag = "R7";
      hold = 3;
      for (int i = 0; i < 3000; i++) begin
         tick();
         cnt = 16'($urandom);
         if (hold == 0) begin pin = ~pin; hold = $urandom_range(1, 8); end
         else hold--;
         if ($urandom_range(0, 199) == 0) flt = 4'($urandom_range(0, 5));
         if ($urandom_range(0, 149) == 0) esel = ~esel;
         if ($urandom_range(0, 99) == 0) psc = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 49) == 0) irq_en = ~irq_en;
         clr = ($urandom_range(0, 15) == 0);
      end
      clr = 0;
      tick();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule